// File: doc/BRIEF.md
# Lightpen Beam-Position Capture Unit

This block records where the electron beam was when a lightpen saw it. It watches the free-running screen-generation counter of a raster video generator, together with two live flags: one that is low while the left and right borders are drawn, and one that is low while the top and bottom borders are drawn. It also watches the pulse from the lightpen sensor. Pixels are visible only when both flags are high.

Software arms the unit by writing a one to bit 0 at address 0. The next synchronised rising edge of the detect input takes a snapshot and then freezes it. The snapshot holds the counter, the frame flag at that moment, and one counter bit that tells the left border from the right. The same edge raises a fast-interrupt request. Later beam hits leave the snapshot untouched, so the handler can read it in several accesses without tearing. Any filtering over several scans is left to software.

Top module: `lpen_capture`

## Requirements
- R1: After reset, `irq_o` is 0, the unit is disarmed, and the latched counter and latched flags all read 0.
- R2: An access with `cs_i`=1, `we_i`=1, `addr_i`=0 and `wdata_i`=1 arms the unit. Suppose the detect input is first sampled high at clock edge k. Then the unit latches the counter value present at edge k+2. The upper byte of the counter, zero-extended to 16 bits, reads at address 0 and the lower byte at address 1.
- R3: Once a capture has happened, further detect pulses do not change the latched values.
- R4: Detect pulses that arrive while the unit is disarmed are ignored: `irq_o` stays 0 and the latched values do not change.
- R5: The live flags can be read at any time. Address 2 bit 6 shows `line_act_i`. Address 3 bit 7 shows `frame_act_i` and address 3 bit 5 shows `line_act_i`. Address 2 bits 5..0 and address 3 bits 4..2 and bit 0 read 0.
- R6: Address 3 bit 6 holds the value that `frame_act_i` had at the capture.
- R7: Address 2 bit 7 holds counter bit `SIDE_BIT` as it was at the capture. A 1 means the right half of the line.
- R8: `irq_o` rises at edge k+2 together with the capture. Address 3 bit 1 mirrors `irq_o`.
- R9: A read of address 0 or address 3 clears `irq_o` at the next edge. A read of address 1 or address 2 does not clear it. If a capture happens in the same cycle as the clearing read, the capture wins.
- R10: An arm write clears the latched values and `irq_o`. If it coincides with a detect edge, the arm write takes priority. A write to address 0 with `wdata_i`=0 has no effect.
- R11: Only a rising edge of detect triggers a capture. If detect is already high when the unit is armed, no capture occurs until detect falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Screen-generation counter |
| line_act_i | input | 1 | Live line flag, low during left/right borders |
| frame_act_i | input | 1 | Live frame flag, low during top/bottom borders |
| detect_i | input | 1 | Lightpen detect, asynchronous |
| cs_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 1 | Write data bit 0 (arm request) |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Fast-interrupt request |

## Verification
The bench builds the unit with `CNT_W`=12 and `SIDE_BIT`=5. This setting keeps a non-empty upper byte and leaves the zero-extension bits visible, while the side bit toggles often enough to exercise both values in a short sweep. About 128 captures spread across the 4096 counter values are each combined with the four flag combinations. Every captured value is predicted by arithmetic on the driven counter. Directed sequences then pin down the capture-cycle timing, the one-shot freeze, the disarmed case, the held-high detect, the effect of each read address on the interrupt, and a capture that coincides with a clearing read.

// File: rtl/lpen_pkg.sv
package lpen_pkg;
  localparam int unsigned REG_W = 16;

  localparam logic [1:0] A_CNT_HI = 2'd0;
  localparam logic [1:0] A_CNT_LO = 2'd1;
  localparam logic [1:0] A_LINE   = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;

  typedef struct packed {
    logic [REG_W-1:0] cnt;
    logic             frame;
    logic             side;
  } cap_t;
endpackage

// File: rtl/lpen_sync.sv
module lpen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/lpen_ctrl.sv
module lpen_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rise_i,
  input  logic clr_rd_i,
  output logic fire_o,
  output logic armed_o,
  output logic irq_o
);
  // arm request beats a coincident detect edge
  assign fire_o = rise_i & armed_o & ~arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (arm_i)       armed_o <= 1'b1;
      else if (fire_o) armed_o <= 1'b0;

      if (arm_i)         irq_o <= 1'b0;
      else if (fire_o)   irq_o <= 1'b1;
      else if (clr_rd_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lpen_latch.sv
module lpen_latch
  import lpen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fire_i,
  input  cap_t smp_i,
  output cap_t cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_o <= '0;
    else if (clr_i)  cap_o <= '0;
    else if (fire_i) cap_o <= smp_i;
  end
endmodule

// File: rtl/lpen_rdmux.sv
module lpen_rdmux
  import lpen_pkg::*;
(
  input  logic [1:0] addr_i,
  input  cap_t       cap_i,
  input  logic       line_act_i,
  input  logic       frame_act_i,
  input  logic       irq_i,
  output logic [7:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CNT_HI: rdata_o = cap_i.cnt[15:8];
      A_CNT_LO: rdata_o = cap_i.cnt[7:0];
      A_LINE: begin
        rdata_o[7] = cap_i.side;
        rdata_o[6] = line_act_i;
      end
      A_STAT: begin
        rdata_o[7] = frame_act_i;
        rdata_o[6] = cap_i.frame;
        rdata_o[5] = line_act_i;
        rdata_o[1] = irq_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lpen_capture.sv
module lpen_capture
  import lpen_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SIDE_BIT = 7,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             line_act_i,
  input  logic             frame_act_i,
  input  logic             detect_i,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [0:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o
);
  logic rise, fire, armed, arm_wr, clr_rd;
  logic [REG_W-1:0] cnt_ext;
  cap_t smp, cap;

  assign arm_wr = cs_i & we_i & (addr_i == A_CNT_HI) & wdata_i[0];
  assign clr_rd = cs_i & ~we_i & ((addr_i == A_CNT_HI) | (addr_i == A_STAT));

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt_i;
  end

  assign smp.cnt   = cnt_ext;
  assign smp.frame = frame_act_i;
  assign smp.side  = cnt_i[SIDE_BIT];

  lpen_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(detect_i), .rise_o(rise)
  );

  lpen_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_wr), .rise_i(rise),
    .clr_rd_i(clr_rd), .fire_o(fire), .armed_o(armed), .irq_o(irq_o)
  );

  lpen_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(arm_wr), .fire_i(fire),
    .smp_i(smp), .cap_o(cap)
  );

  lpen_rdmux u_rdmux (
    .addr_i(addr_i), .cap_i(cap), .line_act_i(line_act_i),
    .frame_act_i(frame_act_i), .irq_i(irq_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/lpen_capture_chk.sv
module lpen_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        armed,
  input logic        fire,
  input logic        arm_wr,
  input logic        clr_rd,
  input logic [15:0] cap_cnt,
  input logic        irq_o,
  input logic        cs_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic        frame_act_i,
  input logic [7:0]  rdata_o
);
  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !arm_wr) |=> $stable(cap_cnt)); // R3

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> armed); // R4

  AST_IRQ_RISE_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fire)); // R8

  AST_READ_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rd && !fire) |=> !irq_o); // R9

  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_wr |=> (!irq_o && cap_cnt == 16'd0 && armed)); // R10

  AST_LIVE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && addr_i == 2'd3) |-> rdata_o[7] == frame_act_i); // R5
endmodule

bind lpen_capture lpen_capture_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .armed(armed), .fire(fire),
  .arm_wr(arm_wr), .clr_rd(clr_rd), .cap_cnt(cap.cnt), .irq_o(irq_o),
  .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i), .frame_act_i(frame_act_i),
  .rdata_o(rdata_o)
);

// File: tb/sim_lpen_capture.sv
module sim_lpen_capture;
  localparam int unsigned CW = 12;
  localparam int unsigned SB = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic line_act = 1'b0, frame_act = 1'b0, detect = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [0:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lpen_capture #(.CNT_W(CW), .SIDE_BIT(SB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .line_act_i(line_act),
    .frame_act_i(frame_act), .detect_i(detect), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr0(input logic b);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = 2'd0; wdata = b;
    @(negedge clk); cs = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  // detect high for 3 edges with counter held; ends after the capture edge
  task automatic hit(input logic [CW-1:0] c, input logic l, input logic f);
    @(negedge clk); cnt = c; line_act = l; frame_act = f; detect = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); detect = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_cap(input string tag, input int c, input logic f);
    logic [7:0] d;
    rd(2'd1, d); chk({tag, " lo"}, d, c & 255);
    rd(2'd2, d); chk({tag, " side R7"}, d[7], (c >> SB) & 1);
    rd(2'd3, d); chk({tag, " frame R6"}, d[6], f);
    rd(2'd0, d); chk({tag, " hi"}, d, c >> 8);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(2'd0, d); chk("R1 hi", d, 0);
    rd(2'd1, d); chk("R1 lo", d, 0);
    rd(2'd3, d); chk("R1 latched frame", d[6], 0);

    // R4 disarmed detection ignored
    hit(12'hABC, 1'b1, 1'b1);
    chk("R4 irq", irq, 0);
    rd(2'd1, d); chk("R4 lo", d, 0);

    // R5 live flags, all combos
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); line_act = k[0]; frame_act = k[1];
      rd(2'd2, d);
      chk("R5 line reg", d & 8'h7F, k[0] ? 8'h40 : 8'h00);
      rd(2'd3, d);
      chk("R5 stat live", d & 8'hBD, (k[1] ? 8'h80 : 8'h00) | (k[0] ? 8'h20 : 8'h00));
    end

    // R2/R8 exact capture timing
    wr0(1'b1);
    @(negedge clk); cnt = 12'h123; frame_act = 1'b1; detect = 1'b1;
    @(negedge clk); chk("R8 irq after k", irq, 0);
    @(negedge clk); chk("R8 irq after k+1", irq, 0);
    cnt = 12'h456;  // this value is present at edge k+2
    @(negedge clk); chk("R8 irq after k+2", irq, 1); detect = 1'b0;
    rd(2'd3, d); chk("R8 stat irq bit", d[1], 1);
    chk_cap("R2 timing", 12'h456, 1'b1);

    // R3 one-shot freeze
    hit(12'h9F0, 1'b0, 1'b0);
    chk("R3 irq stays clear", irq, 0);
    chk_cap("R3 frozen", 12'h456, 1'b1);

    // R9 read clearing rules
    wr0(1'b1); hit(12'h0E1, 1'b0, 1'b0);
    rd(2'd1, d); chk("R9 lo keeps irq", irq, 1);
    rd(2'd2, d); chk("R9 line keeps irq", irq, 1);
    rd(2'd3, d); chk("R9 stat clears irq", irq, 0);
    wr0(1'b1); hit(12'h0E2, 1'b0, 1'b0);
    rd(2'd0, d); chk("R9 hi clears irq", irq, 0);
    // R9 capture wins over coincident clearing read
    wr0(1'b1);
    @(negedge clk); cnt = 12'h777; detect = 1'b1;
    @(negedge clk);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = 2'd3;
    @(negedge clk); cs = 1'b0; detect = 1'b0;
    chk("R9 capture wins", irq, 1);

    // R10 write with bit0=0 has no effect, arm write clears
    wr0(1'b0);
    chk("R10 zero write irq", irq, 1);
    rd(2'd1, d); chk("R10 zero write lo", d, 8'h77);
    wr0(1'b1);
    chk("R10 arm clears irq", irq, 0);
    rd(2'd1, d); chk("R10 arm clears lo", d, 0);
    rd(2'd0, d); chk("R10 arm clears hi", d, 0);

    // R11 detect already high when armed
    @(negedge clk); detect = 1'b1;
    repeat (4) @(negedge clk);
    wr0(1'b1);
    repeat (4) @(negedge clk);
    chk("R11 no capture on level", irq, 0);
    @(negedge clk); detect = 1'b0;
    repeat (3) @(negedge clk);
    hit(12'h3C5, 1'b0, 1'b1);
    chk("R11 capture after new edge", irq, 1);
    chk_cap("R11", 12'h3C5, 1'b1);

    // R2/R6/R7 sweep across counter and flags
    for (int i = 0; i < 128; i++) begin
      int c;
      c = (i * 53 + 7) % 4096;
      wr0(1'b1);
      hit(c[CW-1:0], i[0], i[1]);
      chk("R8 sweep irq", irq, 1);
      chk_cap("R2 sweep", c, i[1]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule